// File: doc/BRIEF.md
# Serial MII Receive Segment Generator

This block sits on the PHY side of a serial MII link. It takes the nibble-wide receive stream that the PCS produces in the recovered-clock domain and turns it into ten-bit receive segments. The segments leave on one serial pin in the reference-clock domain. Each segment carries a live carrier bit, a data-valid bit and one byte. The byte is either frame data or, between frames, a status byte that reports link and duplex.

On the recovered-clock side, nibbles are paired into bytes, low nibble first. At 100 Mbps a received error replaces the affected nibble with a fixed code. At 10 Mbps the preamble is removed so that framing starts at the start-of-frame delimiter. Bytes and end-of-frame markers cross into the reference domain through a small asynchronous elasticity FIFO. The FIFO is drained only after a configurable number of entries has built up, and its read side is realigned to the write side at every frame end.

On the reference side, a sync pulse every ten clocks starts a segment. At 100 Mbps every segment takes a new byte. At 10 Mbps the byte and the data-valid bit are held for ten segments, while the carrier bit is refreshed in every segment.

Top module: `smii_rx_top`

## Requirements
- R1: The clock edge that samples `sync_in` high puts slot 0 of a new segment on `seg_out`. The following nine edges put out slots 1 to 9 in turn. Slot 0 is carrier, slot 1 is data-valid, and slots 2 to 9 are byte bits 0 to 7.
- R2: While the reference-domain reset is active, `seg_out` is 0.
- R3: At 100 Mbps each segment carries a new byte, and a byte is a nibble pair taken low nibble first. Data-valid is high for every byte from the first preamble byte (0x55) through the last frame byte, in order, and drops on the segment after the last byte.
- R4: At 10 Mbps, nibbles of value 0x5 that precede the first 0xD nibble of a frame are dropped. The first data-valid byte is 0x5D.
- R5: At 10 Mbps, slots 1 to 9 stay constant over each group of ten segments. Groups are counted from the first segment after reset, and a new byte is taken only at a group start.
- R6: Slot 0 of every segment, at either speed, equals `rcv_crs` as sampled two reference clocks before the segment's first edge.
- R7: At 100 Mbps a nibble received with `rcv_er` high is replaced by 4'b0101. At 10 Mbps `rcv_er` has no effect on the data.
- R8: While data-valid is low, the byte slots carry the status byte: bit 4 is link up, bit 5 is 1, bit 6 is full duplex, and all other bits are 0.
- R9: Frame bytes are taken from the elasticity FIFO only once it holds at least `FILL` entries, and never from an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, output side |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sync_in | input | 1 | Segment start pulse, one clock every ten |
| spd10 | input | 1 | 1 selects 10 Mbps pacing, 0 selects 100 Mbps |
| link_ok | input | 1 | Link up, reported in status bit 4 |
| fdx | input | 1 | Full duplex, reported in status bit 6 |
| rcv_clk | input | 1 | Recovered receive clock (nibble rate) |
| rcv_crs | input | 1 | Carrier indicator, asynchronous |
| rcv_dv | input | 1 | Nibble data valid |
| rcv_er | input | 1 | Nibble receive error |
| rcv_nib | input | 4 | Receive nibble |
| seg_out | output | 1 | Serial segment output, slot 0 first |

## Verification
The bench builds the block with a FIFO address width of 3 (eight entries) and a start threshold of 2. The threshold makes the wait at frame start visible as a delay of up to two byte periods. The depth leaves room for the extra latency of the gray-pointer synchronizers without ever filling. The bench runs the recovered clock at exactly one byte per segment at 100 Mbps and one byte per ten segments at 10 Mbps, so steady occupancy is exercised at both paces. It switches speed partway through the run, which checks that the ten-segment grouping stays aligned to reset rather than to the switch.

// File: rtl/smii_rx_pkg.sv
`timescale 1ns/1ps
package smii_rx_pkg;

  localparam int SEG_W   = 10;   // bits per segment
  localparam int GRP_LEN = 10;   // segment repeats at the slow pace

  localparam logic [3:0] ERR_NIB    = 4'b0101;
  localparam logic [3:0] SFD_LO_NIB = 4'hD;

  typedef struct packed {
    logic       eof;
    logic [7:0] data;
  } fifo_word_t;

  function automatic logic [7:0] ipg_status(input logic link, input logic full_dup);
    return {1'b0, full_dup, 1'b1, link, 4'b0000};
  endfunction

endpackage

// File: rtl/smii_rst_sync.sv
`timescale 1ns/1ps
module smii_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/smii_rx_pack.sv
`timescale 1ns/1ps
module smii_rx_pack
  import smii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spd10,
  input  logic       dv,
  input  logic       er,
  input  logic [3:0] nib,
  output logic       push,
  output fifo_word_t push_word
);
  logic       dv_q, hunt_q, half_q;
  logic [3:0] lo_q;
  logic       dv_n, hunt_n, half_n;
  logic [3:0] lo_n;

  logic [3:0] nib_eff;
  logic       hunt_cur;
  logic       take;

  always_comb begin
    nib_eff  = (!spd10 && er) ? ERR_NIB : nib;
    // at frame start the hunt state comes from the speed select
    hunt_cur = dv_q ? hunt_q : spd10;
    take     = dv && (!hunt_cur || (nib == SFD_LO_NIB));

    dv_n      = dv;
    hunt_n    = hunt_q;
    half_n    = half_q;
    lo_n      = lo_q;
    push      = 1'b0;
    push_word = '{eof: 1'b0, data: {nib_eff, lo_q}};

    if (dv) begin
      hunt_n = hunt_cur && !take;
      if (take) begin
        if (!half_q) begin
          lo_n   = nib_eff;
          half_n = 1'b1;
        end else begin
          push   = 1'b1;
          half_n = 1'b0;
        end
      end
    end else begin
      half_n = 1'b0;
      hunt_n = 1'b1;
      if (dv_q && !hunt_q) begin
        push      = 1'b1;
        push_word = '{eof: 1'b1, data: 8'h00};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      hunt_q <= 1'b1;
      half_q <= 1'b0;
      lo_q   <= 4'h0;
    end else begin
      dv_q   <= dv_n;
      hunt_q <= hunt_n;
      half_q <= half_n;
      lo_q   <= lo_n;
    end
  end
endmodule

// File: rtl/smii_rx_efifo.sv
`timescale 1ns/1ps
module smii_rx_efifo
  import smii_rx_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        push,
  input  fifo_word_t  wdata,
  output logic        full,
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        pop,
  input  logic        flush,
  output fifo_word_t  rdata,
  output logic [AW:0] level,
  output logic        empty
);
  localparam int DEPTH = 1 << AW;

  fifo_word_t  mem [DEPTH];

  // write domain
  logic [AW:0] wbin_q, wgray_q, wbin_n, wgray_n;
  logic [AW:0] rgray_s1_q, rgray_s2_q;
  logic        wr_go;

  always_comb begin
    full    = (wgray_q == {~rgray_s2_q[AW:AW-1], rgray_s2_q[AW-2:0]});
    wr_go   = push && !full;
    wbin_n  = wbin_q + {{AW{1'b0}}, wr_go};
    wgray_n = wbin_n ^ (wbin_n >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      rgray_s1_q <= '0;
      rgray_s2_q <= '0;
    end else begin
      wbin_q     <= wbin_n;
      wgray_q    <= wgray_n;
      rgray_s1_q <= rgray_q;
      rgray_s2_q <= rgray_s1_q;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // read domain
  logic [AW:0] rbin_q, rgray_q, rbin_n, rgray_n;
  logic [AW:0] wgray_s1_q, wgray_s2_q, wbin_s;

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s2_q >> i);
    level   = wbin_s - rbin_q;
    empty   = (level == '0);
    rdata   = mem[rbin_q[AW-1:0]];
    if (flush)
      rbin_n = wbin_s;
    else
      rbin_n = rbin_q + {{AW{1'b0}}, (pop && !empty)};
    rgray_n = rbin_n ^ (rbin_n >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      wgray_s1_q <= '0;
      wgray_s2_q <= '0;
    end else begin
      rbin_q     <= rbin_n;
      rgray_q    <= rgray_n;
      wgray_s1_q <= wgray_q;
      wgray_s2_q <= wgray_s1_q;
    end
  end
endmodule

// File: rtl/smii_rx_seg.sv
`timescale 1ns/1ps
module smii_rx_seg
  import smii_rx_pkg::*;
#(
  parameter int AW   = 3,
  parameter int FILL = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_in,
  input  logic        spd10,
  input  logic        link_ok,
  input  logic        fdx,
  input  logic        crs_in,
  input  fifo_word_t  rd_word,
  input  logic [AW:0] level,
  input  logic        empty,
  output logic        pop,
  output logic        flush,
  output logic        seg_out
);
  localparam int          REP_W    = $clog2(GRP_LEN);
  localparam logic [AW:0] FILL_LVL = (AW+1)'(FILL);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(GRP_LEN - 1);

  logic             crs_s1_q, crs_s2_q;
  logic [REP_W-1:0] rep_q, rep_n;
  logic             infr_q, infr_n;
  logic             hdv_q, hdv_n;
  logic [7:0]       hbyte_q, hbyte_n;
  logic [SEG_W-2:0] sr_q, sr_n;
  logic             out_q, out_n;

  logic             new_slot;
  logic [7:0]       status;
  logic [SEG_W-1:0] seg_v;

  always_comb begin
    status   = ipg_status(link_ok, fdx);
    new_slot = !spd10 || (rep_q == '0);
    rep_n    = rep_q;
    infr_n   = infr_q;
    hdv_n    = hdv_q;
    hbyte_n  = hbyte_q;
    pop      = 1'b0;
    flush    = 1'b0;

    if (sync_in) begin
      rep_n = (rep_q == REP_LAST) ? '0 : rep_q + 1'b1;
      if (new_slot) begin
        hdv_n   = 1'b0;
        hbyte_n = status;
        if (infr_q || (level >= FILL_LVL)) begin
          if (empty) begin
            infr_n = 1'b0;
            flush  = infr_q;
          end else begin
            pop = 1'b1;
            if (rd_word.eof) begin
              infr_n = 1'b0;
              flush  = 1'b1;
            end else begin
              infr_n  = 1'b1;
              hdv_n   = 1'b1;
              hbyte_n = rd_word.data;
            end
          end
        end
      end
    end

    seg_v = {hbyte_n, hdv_n, crs_s2_q};
    if (sync_in) begin
      out_n = seg_v[0];
      sr_n  = seg_v[SEG_W-1:1];
    end else begin
      out_n = sr_q[0];
      sr_n  = {1'b0, sr_q[SEG_W-2:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crs_s1_q <= 1'b0;
      crs_s2_q <= 1'b0;
      rep_q    <= '0;
      infr_q   <= 1'b0;
      hdv_q    <= 1'b0;
      hbyte_q  <= 8'h00;
      sr_q     <= '0;
      out_q    <= 1'b0;
    end else begin
      crs_s1_q <= crs_in;
      crs_s2_q <= crs_s1_q;
      rep_q    <= rep_n;
      infr_q   <= infr_n;
      hdv_q    <= hdv_n;
      hbyte_q  <= hbyte_n;
      sr_q     <= sr_n;
      out_q    <= out_n;
    end
  end

  assign seg_out = out_q;
endmodule

// File: rtl/smii_rx_top.sv
`timescale 1ns/1ps
module smii_rx_top
  import smii_rx_pkg::*;
#(
  parameter int AW   = 3,
  parameter int FILL = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       spd10,
  input  logic       link_ok,
  input  logic       fdx,
  input  logic       rcv_clk,
  input  logic       rcv_crs,
  input  logic       rcv_dv,
  input  logic       rcv_er,
  input  logic [3:0] rcv_nib,
  output logic       seg_out
);
  logic        ref_rst_n, rcv_rst_n;
  logic        push_w, full_w, pop_w, flush_w, empty_w;
  fifo_word_t  push_word_w, rd_word_w;
  logic [AW:0] level_w;

  smii_rst_sync u_rst_ref (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));
  smii_rst_sync u_rst_rcv (.clk(rcv_clk), .arst_n(rst_n), .srst_n(rcv_rst_n));

  smii_rx_pack u_pack (
    .clk(rcv_clk), .rst_n(rcv_rst_n), .spd10(spd10),
    .dv(rcv_dv), .er(rcv_er), .nib(rcv_nib),
    .push(push_w), .push_word(push_word_w)
  );

  smii_rx_efifo #(.AW(AW)) u_fifo (
    .wclk(rcv_clk), .wrst_n(rcv_rst_n), .push(push_w), .wdata(push_word_w), .full(full_w),
    .rclk(ref_clk), .rrst_n(ref_rst_n), .pop(pop_w), .flush(flush_w),
    .rdata(rd_word_w), .level(level_w), .empty(empty_w)
  );

  smii_rx_seg #(.AW(AW), .FILL(FILL)) u_seg (
    .clk(ref_clk), .rst_n(ref_rst_n), .sync_in(sync_in), .spd10(spd10),
    .link_ok(link_ok), .fdx(fdx), .crs_in(rcv_crs),
    .rd_word(rd_word_w), .level(level_w), .empty(empty_w),
    .pop(pop_w), .flush(flush_w), .seg_out(seg_out)
  );
endmodule

// File: rtl/smii_rx_chk.sv
`timescale 1ns/1ps
module smii_rx_chk #(
  parameter int AW   = 3,
  parameter int FILL = 2
) (
  input logic        ref_clk,
  input logic        rcv_clk,
  input logic        ref_rst_n,
  input logic        rcv_rst_n,
  input logic        sync_in,
  input logic        spd10,
  input logic        seg_out,
  input logic        pop,
  input logic        flush,
  input logic        empty,
  input logic [AW:0] level,
  input logic        push,
  input logic        full
);
  localparam logic [AW:0] FILL_LVL = (AW+1)'(FILL);

  logic [3:0] grp_q;
  logic       infr_q;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      grp_q  <= 4'd0;
      infr_q <= 1'b0;
    end else begin
      if (sync_in) grp_q <= (grp_q == 4'd9) ? 4'd0 : grp_q + 4'd1;
      if (flush)       infr_q <= 1'b0;
      else if (pop)    infr_q <= 1'b1;
    end
  end

  assert_reset_quiet_R2: assert property (@(posedge ref_clk)
    !ref_rst_n |-> !seg_out);

  assert_pop_nonempty_R9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    pop |-> !empty);

  assert_start_fill_R9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (pop && !infr_q) |-> (level >= FILL_LVL));

  assert_push_room_R9: assert property (@(posedge rcv_clk) disable iff (!rcv_rst_n)
    push |-> !full);

  assert_pop_on_load_R1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (pop || flush) |-> sync_in);

  assert_group_start_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (pop && spd10) |-> (grp_q == 4'd0));
endmodule

bind smii_rx_top smii_rx_chk #(.AW(AW), .FILL(FILL)) u_chk (
  .ref_clk(ref_clk), .rcv_clk(rcv_clk),
  .ref_rst_n(ref_rst_n), .rcv_rst_n(rcv_rst_n),
  .sync_in(sync_in), .spd10(spd10), .seg_out(seg_out),
  .pop(pop_w), .flush(flush_w), .empty(empty_w), .level(level_w),
  .push(push_w), .full(full_w)
);

// File: tb/test_smii_rx_top.sv
`timescale 1ns/1ps
module test_smii_rx_top;

  localparam int EOF_MARK = 256;

  logic       ref_clk = 1'b0;
  logic       rcv_clk;
  real        rcv_half = 12.5;
  logic       rst_n, sync_in, spd10, link_ok, fdx;
  logic       rcv_crs, rcv_dv, rcv_er;
  logic [3:0] rcv_nib;
  logic       seg_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  bit sync_run = 0;
  bit chk_en = 0;

  int    exp_q[$];
  string tag_q[$];

  smii_rx_top #(.AW(3), .FILL(2)) i_smii_rx_top (
    .ref_clk(ref_clk), .rst_n(rst_n), .sync_in(sync_in), .spd10(spd10),
    .link_ok(link_ok), .fdx(fdx), .rcv_clk(rcv_clk), .rcv_crs(rcv_crs),
    .rcv_dv(rcv_dv), .rcv_er(rcv_er), .rcv_nib(rcv_nib), .seg_out(seg_out)
  );

  always #2.5 ref_clk = ~ref_clk;

  initial begin
    rcv_clk = 1'b0;
    #1.3;
    forever #(rcv_half) rcv_clk = ~rcv_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // sync pulse generator
  int scnt = 0;
  always @(negedge ref_clk) begin
    if (!sync_run) begin
      sync_in <= 1'b0;
      scnt    <= 0;
    end else begin
      sync_in <= (scnt == 0);
      scnt    <= (scnt == 9) ? 0 : scnt + 1;
    end
  end

  // monitor: deserialize and score
  int         pos = 10;
  logic [9:0] bits;
  logic [1:0] crs_h;
  logic       ld_crs;
  int         seg_k = 0;
  logic [8:0] grp_v;
  bit         mon_inf = 0;

  always @(posedge ref_clk) begin
    crs_h <= {crs_h[0], rcv_crs};
    if (sync_in) begin
      pos    <= 0;
      ld_crs <= crs_h[1];
    end else if (pos < 10) begin
      pos <= pos + 1;
    end
  end

  task automatic score_segment();
    logic [7:0] d;
    logic       dv;
    logic [7:0] st;
    int         grp;
    bit         ns;
    int         e;
    string      t;
    d   = bits[9:2];
    dv  = bits[1];
    st  = {1'b0, fdx, 1'b1, link_ok, 4'b0000};
    grp = seg_k % 10;
    ns  = !spd10 || (grp == 0);
    chk(bits[0] === ld_crs, "R6 carrier slot (R1 slot 0)", bits[0], ld_crs);
    if (ns) begin
      if (dv) begin
        if (exp_q.size() == 0 || exp_q[0] == EOF_MARK) begin
          chk(0, "R3 data-valid outside an expected frame", d, -1);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(d === e[7:0], t, d, e);
        end
        mon_inf = 1;
      end else begin
        if (mon_inf) begin
          if (exp_q.size() > 0 && exp_q[0] == EOF_MARK) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(1, t, 0, 0);
          end else begin
            chk(0, "R3 frame ended early", exp_q.size(), 0);
          end
          mon_inf = 0;
        end
        if (chk_en) chk(d === st, "R8 status byte between frames", d, st);
      end
    end else if (chk_en) begin
      chk({d, dv} === grp_v, "R5 slots held over ten-segment group", {d, dv}, grp_v);
    end
    if (grp == 0) grp_v = {d, dv};
    seg_k++;
  endtask

  always @(negedge ref_clk) begin
    if (pos < 10) begin
      bits[pos] = seg_out;
      if (pos == 9) score_segment();
    end
  end

  // driver
  task automatic send_frame(input bit ten, input int n, input int seed, input int err_byte);
    int nibs[$];
    int b, e;
    for (int i = 0; i < 14; i++) nibs.push_back(5);
    nibs.push_back(13);
    nibs.push_back(5);
    if (!ten) begin
      for (int i = 0; i < 7; i++) begin exp_q.push_back(8'h55); tag_q.push_back("R3 preamble byte"); end
      exp_q.push_back(8'h5D); tag_q.push_back("R3 delimiter byte");
    end else begin
      exp_q.push_back(8'h5D); tag_q.push_back("R4 first byte after stripped preamble");
    end
    for (int i = 0; i < n; i++) begin
      b = (seed + i * 37) & 255;
      nibs.push_back(b & 15);
      nibs.push_back(b >> 4);
      e = b;
      if (i == err_byte && !ten) e = (5 << 4) | (b & 15);
      exp_q.push_back(e);
      if (i == err_byte) tag_q.push_back(ten ? "R7 error flag ignored at 10M" : "R7 error nibble substituted");
      else               tag_q.push_back(ten ? "R4 data byte" : "R3 data byte");
    end
    exp_q.push_back(EOF_MARK); tag_q.push_back("R3 data-valid drops after last byte");

    @(negedge ref_clk) rcv_crs = 1'b1;
    foreach (nibs[k]) begin
      @(negedge rcv_clk);
      rcv_dv  = 1'b1;
      rcv_nib = nibs[k][3:0];
      rcv_er  = (err_byte >= 0) && (k == 16 + 2 * err_byte + 1);
    end
    @(negedge rcv_clk);
    rcv_dv = 1'b0; rcv_er = 1'b0; rcv_nib = 4'h0;
    @(negedge ref_clk) rcv_crs = 1'b0;
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge ref_clk);
  endtask

  task automatic set_config(input bit s10, input bit lk, input bit fd);
    chk_en = 0;
    @(negedge ref_clk);
    spd10 = s10; link_ok = lk; fdx = fd;
    rcv_half = s10 ? 125.0 : 12.5;
    repeat (300) @(negedge ref_clk);
    chk_en = 1;
  endtask

  initial begin
    rst_n = 1'b0; spd10 = 1'b0; link_ok = 1'b1; fdx = 1'b1;
    rcv_crs = 1'b0; rcv_dv = 1'b0; rcv_er = 1'b0; rcv_nib = 4'h0;
    repeat (3) @(negedge ref_clk);
    for (int i = 0; i < 3; i++) begin
      chk(seg_out === 1'b0, "R2 output low in reset", seg_out, 0);
      @(negedge ref_clk);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge ref_clk);
    chk(seg_out === 1'b0, "R2 output low before first segment", seg_out, 0);
    sync_run = 1;
    repeat (40) @(negedge ref_clk);
    chk_en = 1;
    repeat (100) @(negedge ref_clk);

    // carrier alone at 100M
    rcv_crs = 1'b1;
    repeat (43) @(negedge ref_clk);
    rcv_crs = 1'b0;
    repeat (60) @(negedge ref_clk);

    send_frame(0, 6, 8'h12, -1);
    repeat (40) @(negedge rcv_clk);
    send_frame(0, 10, 8'hA7, 3);
    drain(2000);
    repeat (50) @(negedge ref_clk);

    set_config(0, 0, 0);
    repeat (100) @(negedge ref_clk);
    set_config(0, 1, 0);
    send_frame(0, 4, 8'h3C, 0);
    drain(2000);

    set_config(1, 1, 1);
    rcv_crs = 1'b1;
    repeat (23) @(negedge ref_clk);
    rcv_crs = 1'b0;
    repeat (37) @(negedge ref_clk);
    rcv_crs = 1'b1;
    repeat (14) @(negedge ref_clk);
    rcv_crs = 1'b0;
    repeat (200) @(negedge ref_clk);

    send_frame(1, 5, 8'h61, -1);
    repeat (30) @(negedge rcv_clk);
    send_frame(1, 4, 8'hC3, 2);
    drain(20000);
    repeat (400) @(negedge ref_clk);

    chk(exp_q.size() == 0, "R3 all expected bytes delivered", exp_q.size(), 0);
    chk(!mon_inf, "R3 no frame left open", mon_inf, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired R3 actual=%0d expected=0 pending", exp_q.size());
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule